// File: doc/BRIEF.md
# NAND Flash Page Read Sequencer

This block drives the shared 8-bit bus of a NAND flash device. It can run two operations. The first reads the device identifier. The second loads one full page, with its spare area, and delivers it as a byte stream. On this bus, command bytes, address bytes and data bytes all travel on the same eight lines. A command-latch strobe marks command bytes and an address-latch strobe marks address bytes. Write-enable and read-enable pulses move each byte. Three 4-bit timing inputs set how long each part of a bus cycle lasts.

The host sets the timing, the page address and the operation select, then pulses `start_i`. The block accepts the request only when the controller enable is set and the chip-enable control bit is cleared. `busy_o` stays high until a one-cycle `done_o` pulse. Each byte read from the device appears on `rd_data_o` with a one-cycle `rd_valid_o`. Bytes from the spare area also carry `rd_spare_o`, so a consumer can drop them. If the device never reports ready within a programmable number of polls, the operation ends with `err_o` set and no data is read.

Top module: `nfr_page_reader`

## Requirements
- R1: While reset is held and after its release, the bus is idle: `nf_cle_o`=0, `nf_ale_o`=0, `nf_nwe_o`=1, `nf_nre_o`=1, `nf_dq_oe_o`=0. The host side is also idle: `busy_o`=0, `done_o`=0, `rd_valid_o`=0.
- R2: `nf_nce_o` equals `ce_off_i`. The block ignores `start_i` unless `en_i`=1 and `ce_off_i`=0.
- R3: Every bus cycle follows one idle cycle and has three phases. A setup phase of `tacls_i` cycles comes first. A strobe phase of `twrph0_i`+1 cycles follows, with `nf_nwe_o` low for command and address bytes and `nf_nre_o` low for reads. A hold phase of `twrph1_i`+1 cycles ends the bus cycle. On command and address bytes, the latch strobe and the driven data stay valid through all three phases.
- R4: A page read sends command byte 0x00, then five address bytes, then command byte 0x30. The address bytes are, in order: `page_addr_i[7:0]`, `{5'b0,page_addr_i[10:8]}`, `page_addr_i[18:11]`, `page_addr_i[26:19]`, `{7'b0,page_addr_i[27]}`. Command bytes use `nf_cle_o`=1 and address bytes use `nf_ale_o`=1.
- R5: After command 0x30 the block spends 4 cycles without looking at ready/busy. It then polls the ready/busy input once per cycle through a two-flop synchronizer. The first read cycle starts in the cycle after a poll sees ready (1).
- R6: Each poll that sees busy increments a counter. If a poll sees busy while the counter equals `busy_limit_i`, the next cycle is the done cycle with `err_o`=1, and no read cycle runs. `err_o` is high only in the done cycle.
- R7: A page read runs 2112 read cycles. The byte on `nf_dq_i` is captured in the last strobe cycle. It appears on `rd_data_o` with `rd_valid_o`=1 for exactly the first hold cycle. Bytes 2048 to 2111 have `rd_spare_o`=1 and the earlier bytes have 0.
- R8: A read-ID operation (`op_id_i`=1) sends command 0x90 and then one address byte 0x00. It then runs 5 read cycles with `rd_spare_o`=0, and it never sends 0x30 or polls ready/busy.
- R9: `busy_o` rises in the cycle after `start_i` is accepted. `done_o` is a one-cycle pulse in the cycle after the last bus cycle (or after the timeout poll). `busy_o` falls in the cycle after the pulse. A successful operation ends with `err_o`=0.
- R10: `nf_nwe_o` and `nf_nre_o` are never low together, `nf_cle_o` and `nf_ale_o` are never high together, and `nf_dq_oe_o` is never high while `nf_nre_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Controller enable; start is refused while low |
| ce_off_i | input | 1 | Chip-enable control bit; 1 forces chip enable inactive |
| start_i | input | 1 | Start pulse for one operation |
| op_id_i | input | 1 | 1 = read ID, 0 = page read |
| page_addr_i | input | 28 | Byte address of the page |
| tacls_i | input | 4 | Setup length in cycles |
| twrph0_i | input | 4 | Strobe length minus one |
| twrph1_i | input | 4 | Hold length minus one |
| busy_limit_i | input | 16 | Busy polls tolerated before timeout |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle end-of-operation pulse |
| err_o | output | 1 | Timeout flag, valid with done_o |
| nf_cle_o | output | 1 | Command latch enable |
| nf_ale_o | output | 1 | Address latch enable |
| nf_nce_o | output | 1 | Chip enable, active low |
| nf_nwe_o | output | 1 | Write enable, active low |
| nf_nre_o | output | 1 | Read enable, active low |
| nf_dq_o | output | 8 | Byte driven onto the shared bus |
| nf_dq_oe_o | output | 1 | Output enable for nf_dq_o |
| nf_dq_i | input | 8 | Byte read from the shared bus |
| nf_rb_i | input | 1 | Ready (1) / busy (0) from the device |
| rd_valid_o | output | 1 | A read byte is present |
| rd_data_o | output | 8 | Read byte |
| rd_spare_o | output | 1 | Read byte belongs to the spare area |

## Verification
Some properties are checked by assertions on every cycle. These are the mutual exclusion of the strobes, of the latch signals and of bus drive against read (R10), the single-cycle done pulse, the pairing of the error flag with done, the pairing of a read byte with a read strobe just before it, and the refusal to start while disabled. Other behaviours only the bench's scenarios can show. These are the exact phase lengths for several timing settings, the address byte order, the ignore window and synchronizer delay before polling, the timeout point, and the spare-area boundary at byte 2048. The bench shows them by comparing every pin against a behavioural model on each clock.

// File: rtl/nfr_pkg.sv
package nfr_pkg;
    localparam int DQ_W        = 8;
    localparam int ADDR_W      = 28;
    localparam int TIM_W       = 4;
    localparam int ADDR_CYCLES = 5;

    localparam logic [DQ_W-1:0] CMD_PAGE_SETUP = 8'h00;
    localparam logic [DQ_W-1:0] CMD_PAGE_GO    = 8'h30;
    localparam logic [DQ_W-1:0] CMD_READ_ID    = 8'h90;

    typedef enum logic [1:0] {BUS_CMD, BUS_ADDR, BUS_READ} bus_kind_e;
    typedef enum logic [1:0] {PH_IDLE, PH_SETUP, PH_STROBE, PH_HOLD} phase_e;
    typedef enum logic [2:0] {
        SQ_IDLE, SQ_CMD1, SQ_ADDR, SQ_CMD2, SQ_BLANK, SQ_POLL, SQ_READ, SQ_DONE
    } seq_e;

    typedef struct packed {
        bus_kind_e       kind;
        logic [DQ_W-1:0] wbyte;
        logic            spare;
    } bus_req_t;

    typedef struct packed {
        logic [TIM_W-1:0] setup;
        logic [TIM_W-1:0] strobe;
        logic [TIM_W-1:0] hold;
    } timing_t;

    // Address byte i of a page read; the split follows the device's column/row layout.
    function automatic logic [DQ_W-1:0] addr_byte(input logic [ADDR_W-1:0] a, input logic [2:0] i);
        case (i)
            3'd0:    return a[7:0];
            3'd1:    return {5'b0, a[10:8]};
            3'd2:    return a[18:11];
            3'd3:    return a[26:19];
            default: return {7'b0, a[27]};
        endcase
    endfunction
endpackage

// File: rtl/nfr_sync.sv
module nfr_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] sh;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) sh <= '0;
                else     sh <= d_i;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst) sh <= '0;
                else     sh <= {sh[STAGES-2:0], d_i};
            end
        end
    endgenerate

    assign q_o = sh[STAGES-1];
endmodule

// File: rtl/nfr_bus_engine.sv
module nfr_bus_engine
    import nfr_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            req_i,
    input  bus_req_t        req_d_i,
    input  timing_t         tim_i,
    input  logic [DQ_W-1:0] dq_i,
    output logic            idle_o,
    output logic            done_o,
    output logic            cle_o,
    output logic            ale_o,
    output logic            nwe_o,
    output logic            nre_o,
    output logic [DQ_W-1:0] dq_o,
    output logic            dq_oe_o,
    output logic            rd_valid_o,
    output logic [DQ_W-1:0] rd_data_o,
    output logic            rd_spare_o
);
    phase_e           phase;
    logic [TIM_W-1:0] cnt;
    logic [TIM_W-1:0] strobe_r;
    logic [TIM_W-1:0] hold_r;
    bus_req_t         cur;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase      <= PH_IDLE;
            cnt        <= '0;
            strobe_r   <= '0;
            hold_r     <= '0;
            cur        <= '0;
            rd_valid_o <= 1'b0;
            rd_data_o  <= '0;
            rd_spare_o <= 1'b0;
        end else begin
            rd_valid_o <= 1'b0;
            case (phase)
                PH_IDLE: if (req_i) begin
                    cur      <= req_d_i;
                    strobe_r <= tim_i.strobe;
                    hold_r   <= tim_i.hold;
                    if (tim_i.setup != '0) begin
                        phase <= PH_SETUP;
                        cnt   <= tim_i.setup - 1'b1;
                    end else begin
                        phase <= PH_STROBE;
                        cnt   <= tim_i.strobe;
                    end
                end
                PH_SETUP: if (cnt == '0) begin
                    phase <= PH_STROBE;
                    cnt   <= strobe_r;
                end else begin
                    cnt <= cnt - 1'b1;
                end
                PH_STROBE: if (cnt == '0) begin
                    phase <= PH_HOLD;
                    cnt   <= hold_r;
                    if (cur.kind == BUS_READ) begin
                        rd_valid_o <= 1'b1;
                        rd_data_o  <= dq_i;
                        rd_spare_o <= cur.spare;
                    end
                end else begin
                    cnt <= cnt - 1'b1;
                end
                default: if (cnt == '0) phase <= PH_IDLE;
                         else           cnt   <= cnt - 1'b1;
            endcase
        end
    end

    logic active;
    assign active  = (phase != PH_IDLE);
    assign idle_o  = !active;
    assign done_o  = (phase == PH_HOLD) && (cnt == '0);
    assign cle_o   = active && (cur.kind == BUS_CMD);
    assign ale_o   = active && (cur.kind == BUS_ADDR);
    assign nwe_o   = !((phase == PH_STROBE) && (cur.kind != BUS_READ));
    assign nre_o   = !((phase == PH_STROBE) && (cur.kind == BUS_READ));
    assign dq_oe_o = active && (cur.kind != BUS_READ);
    assign dq_o    = cur.wbyte;

    a_r10_strobe_excl: assert property (@(posedge clk) disable iff (rst)
        !(!nwe_o && !nre_o));
    a_r10_latch_excl: assert property (@(posedge clk) disable iff (rst)
        !(cle_o && ale_o));
    a_r10_no_drive_on_read: assert property (@(posedge clk) disable iff (rst)
        !nre_o |-> !dq_oe_o);
    a_r7_valid_after_read: assert property (@(posedge clk) disable iff (rst)
        rd_valid_o |-> ($past(phase) == PH_STROBE && $past(cur.kind) == BUS_READ));
    a_r3_hold_after_strobe: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_HOLD && $past(phase) != PH_HOLD) |-> $past(phase) == PH_STROBE);
endmodule

// File: rtl/nfr_seq.sv
module nfr_seq
    import nfr_pkg::*;
#(
    parameter int PAGE_BYTES  = 2048,
    parameter int SPARE_BYTES = 64,
    parameter int ID_BYTES    = 5,
    parameter int BLANK_CYC   = 4,
    parameter int TMO_W       = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic              en_i,
    input  logic              ce_off_i,
    input  logic              op_id_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [TMO_W-1:0]  limit_i,
    input  logic              rb_s_i,
    input  logic              eng_idle_i,
    input  logic              eng_done_i,
    output logic              req_o,
    output bus_req_t          req_d_o,
    output logic              busy_o,
    output logic              done_o,
    output logic              err_o
);
    localparam int TOTAL_BYTES = PAGE_BYTES + SPARE_BYTES;
    localparam int CNT_W       = $clog2(TOTAL_BYTES);
    localparam logic [CNT_W-1:0] LAST_PAGE  = CNT_W'(TOTAL_BYTES - 1);
    localparam logic [CNT_W-1:0] LAST_ID    = CNT_W'(ID_BYTES - 1);
    localparam logic [CNT_W-1:0] LAST_ADDR  = CNT_W'(ADDR_CYCLES - 1);
    localparam logic [CNT_W-1:0] SPARE_BASE = CNT_W'(PAGE_BYTES);
    localparam logic [TMO_W-1:0] BLANK_END  = TMO_W'(BLANK_CYC - 1);

    seq_e              state;
    logic              is_id;
    logic [ADDR_W-1:0] addr_r;
    logic [CNT_W-1:0]  idx;
    logic [TMO_W-1:0]  wcnt;
    logic              err_r;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= SQ_IDLE;
            is_id  <= 1'b0;
            addr_r <= '0;
            idx    <= '0;
            wcnt   <= '0;
            err_r  <= 1'b0;
        end else begin
            case (state)
                SQ_IDLE: if (start_i && en_i && !ce_off_i) begin
                    state  <= SQ_CMD1;
                    is_id  <= op_id_i;
                    addr_r <= addr_i;
                    idx    <= '0;
                    err_r  <= 1'b0;
                end
                SQ_CMD1: if (eng_done_i) begin
                    state <= SQ_ADDR;
                    idx   <= '0;
                end
                SQ_ADDR: if (eng_done_i) begin
                    if (is_id) begin
                        state <= SQ_READ;
                        idx   <= '0;
                    end else if (idx == LAST_ADDR) begin
                        state <= SQ_CMD2;
                    end else begin
                        idx <= idx + 1'b1;
                    end
                end
                SQ_CMD2: if (eng_done_i) begin
                    state <= SQ_BLANK;
                    wcnt  <= '0;
                end
                SQ_BLANK: if (wcnt == BLANK_END) begin
                    state <= SQ_POLL;
                    wcnt  <= '0;
                end else begin
                    wcnt <= wcnt + 1'b1;
                end
                SQ_POLL: if (rb_s_i) begin
                    state <= SQ_READ;
                    idx   <= '0;
                end else if (wcnt == limit_i) begin
                    state <= SQ_DONE;
                    err_r <= 1'b1;
                end else begin
                    wcnt <= wcnt + 1'b1;
                end
                SQ_READ: if (eng_done_i) begin
                    if (idx == (is_id ? LAST_ID : LAST_PAGE)) state <= SQ_DONE;
                    else                                      idx   <= idx + 1'b1;
                end
                default: state <= SQ_IDLE;
            endcase
        end
    end

    always_comb begin
        req_d_o = '{kind: BUS_CMD, wbyte: '0, spare: 1'b0};
        case (state)
            SQ_CMD1: req_d_o.wbyte = is_id ? CMD_READ_ID : CMD_PAGE_SETUP;
            SQ_ADDR: begin
                req_d_o.kind  = BUS_ADDR;
                req_d_o.wbyte = is_id ? '0 : addr_byte(addr_r, idx[2:0]);
            end
            SQ_CMD2: req_d_o.wbyte = CMD_PAGE_GO;
            SQ_READ: begin
                req_d_o.kind  = BUS_READ;
                req_d_o.spare = !is_id && (idx >= SPARE_BASE);
            end
            default: ;
        endcase
    end

    assign req_o  = eng_idle_i && (state == SQ_CMD1 || state == SQ_ADDR ||
                                   state == SQ_CMD2 || state == SQ_READ);
    assign busy_o = (state != SQ_IDLE);
    assign done_o = (state == SQ_DONE);
    assign err_o  = err_r && (state == SQ_DONE);

    a_r9_done_single: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);
    a_r6_err_with_done: assert property (@(posedge clk) disable iff (rst)
        err_o |-> done_o);
    a_r5_poll_after_blank: assert property (@(posedge clk) disable iff (rst)
        (state == SQ_POLL && $past(state) != SQ_POLL) |-> $past(state) == SQ_BLANK);
    a_r8_id_skips_wait: assert property (@(posedge clk) disable iff (rst)
        is_id |-> (state != SQ_CMD2 && state != SQ_POLL && state != SQ_BLANK));
endmodule

// File: rtl/nfr_page_reader.sv
module nfr_page_reader
    import nfr_pkg::*;
#(
    parameter int PAGE_BYTES  = 2048,
    parameter int SPARE_BYTES = 64,
    parameter int ID_BYTES    = 5,
    parameter int BLANK_CYC   = 4,
    parameter int SYNC_STAGES = 2,
    parameter int TMO_W       = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en_i,
    input  logic              ce_off_i,
    input  logic              start_i,
    input  logic              op_id_i,
    input  logic [ADDR_W-1:0] page_addr_i,
    input  logic [TIM_W-1:0]  tacls_i,
    input  logic [TIM_W-1:0]  twrph0_i,
    input  logic [TIM_W-1:0]  twrph1_i,
    input  logic [TMO_W-1:0]  busy_limit_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              err_o,
    output logic              nf_cle_o,
    output logic              nf_ale_o,
    output logic              nf_nce_o,
    output logic              nf_nwe_o,
    output logic              nf_nre_o,
    output logic [DQ_W-1:0]   nf_dq_o,
    output logic              nf_dq_oe_o,
    input  logic [DQ_W-1:0]   nf_dq_i,
    input  logic              nf_rb_i,
    output logic              rd_valid_o,
    output logic [DQ_W-1:0]   rd_data_o,
    output logic              rd_spare_o
);
    logic     rb_s;
    logic     eng_idle;
    logic     eng_done;
    logic     req;
    bus_req_t req_d;
    timing_t  tim;

    assign tim      = '{setup: tacls_i, strobe: twrph0_i, hold: twrph1_i};
    assign nf_nce_o = ce_off_i;

    nfr_sync #(.STAGES(SYNC_STAGES)) u_rb_sync (
        .clk (clk),
        .rst (rst),
        .d_i (nf_rb_i),
        .q_o (rb_s)
    );

    nfr_seq #(
        .PAGE_BYTES  (PAGE_BYTES),
        .SPARE_BYTES (SPARE_BYTES),
        .ID_BYTES    (ID_BYTES),
        .BLANK_CYC   (BLANK_CYC),
        .TMO_W       (TMO_W)
    ) u_seq (
        .clk        (clk),
        .rst        (rst),
        .start_i    (start_i),
        .en_i       (en_i),
        .ce_off_i   (ce_off_i),
        .op_id_i    (op_id_i),
        .addr_i     (page_addr_i),
        .limit_i    (busy_limit_i),
        .rb_s_i     (rb_s),
        .eng_idle_i (eng_idle),
        .eng_done_i (eng_done),
        .req_o      (req),
        .req_d_o    (req_d),
        .busy_o     (busy_o),
        .done_o     (done_o),
        .err_o      (err_o)
    );

    nfr_bus_engine u_engine (
        .clk        (clk),
        .rst        (rst),
        .req_i      (req),
        .req_d_i    (req_d),
        .tim_i      (tim),
        .dq_i       (nf_dq_i),
        .idle_o     (eng_idle),
        .done_o     (eng_done),
        .cle_o      (nf_cle_o),
        .ale_o      (nf_ale_o),
        .nwe_o      (nf_nwe_o),
        .nre_o      (nf_nre_o),
        .dq_o       (nf_dq_o),
        .dq_oe_o    (nf_dq_oe_o),
        .rd_valid_o (rd_valid_o),
        .rd_data_o  (rd_data_o),
        .rd_spare_o (rd_spare_o)
    );

    a_r2_refuse_when_off: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && !(en_i && !ce_off_i)) |=> !busy_o);
endmodule

// File: tb/nfr_page_reader_tb.sv
module nfr_page_reader_tb;
    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic        rst = 1'b1;
    logic        en = 1'b0, ce_off = 1'b1, start = 1'b0, op_id = 1'b0;
    logic [27:0] addr = '0;
    logic [3:0]  tacls = '0, tw0 = '0, tw1 = '0;
    logic [15:0] limit = '0;
    logic        nf_rb = 1'b1;
    logic [7:0]  nf_dq_i;
    logic        busy_o, done_o, err_o, nf_cle_o, nf_ale_o, nf_nce_o, nf_nwe_o, nf_nre_o;
    logic [7:0]  nf_dq_o, rd_data_o;
    logic        nf_dq_oe_o, rd_valid_o, rd_spare_o;

    int n_chk = 0, n_err = 0;
    int rd_cnt = 0, rd_base = 0;
    logic [7:0] seed = 8'h00;
    logic rb_drv = 1'b1, ms1 = 1'b0, ms2 = 1'b0;

    nfr_page_reader u_dut (
        .clk(clk), .rst(rst), .en_i(en), .ce_off_i(ce_off), .start_i(start),
        .op_id_i(op_id), .page_addr_i(addr), .tacls_i(tacls), .twrph0_i(tw0),
        .twrph1_i(tw1), .busy_limit_i(limit), .busy_o(busy_o), .done_o(done_o),
        .err_o(err_o), .nf_cle_o(nf_cle_o), .nf_ale_o(nf_ale_o), .nf_nce_o(nf_nce_o),
        .nf_nwe_o(nf_nwe_o), .nf_nre_o(nf_nre_o), .nf_dq_o(nf_dq_o),
        .nf_dq_oe_o(nf_dq_oe_o), .nf_dq_i(nf_dq_i), .nf_rb_i(nf_rb),
        .rd_valid_o(rd_valid_o), .rd_data_o(rd_data_o), .rd_spare_o(rd_spare_o)
    );

    // Device model: byte stream advances on each rising read strobe.
    function automatic logic [7:0] pat(input int n);
        logic [31:0] v;
        v = n * 7 + int'(seed);
        return v[7:0] ^ v[15:8];
    endfunction
    always @(posedge nf_nre_o) rd_cnt <= rd_cnt + 1;
    assign nf_dq_i = pat(rd_cnt - rd_base);

    task automatic chk(input string tg, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s act=%h exp=%h t=%0t", tg, act, exp, $time);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        ms2 = ms1;
        ms1 = nf_rb;
    endtask

    // One clock of expected behaviour, compared at the falling edge.
    task automatic cyc(input logic e_cle, e_ale, e_nwe, e_nre, e_oe, input logic [7:0] e_dq,
                       input logic e_ov, input logic [7:0] e_od, input logic e_sp,
                       input logic e_bsy, e_dn, e_er, input logic go, input string tg);
        @(negedge clk);
        chk("R3 cle", nf_cle_o, e_cle);
        chk("R3 ale", nf_ale_o, e_ale);
        chk("R3 nwe", nf_nwe_o, e_nwe);
        chk("R3 nre", nf_nre_o, e_nre);
        chk("R3 oe", nf_dq_oe_o, e_oe);
        if (e_oe) chk("R4 dq", nf_dq_o, e_dq);
        chk("R10 strobes", !(!nf_nwe_o && !nf_nre_o), 1);
        chk({tg, " rd_valid"}, rd_valid_o, e_ov);
        if (e_ov) begin
            chk({tg, " rd_data"}, rd_data_o, e_od);
            chk({tg, " rd_spare"}, rd_spare_o, e_sp);
        end
        chk("R9 busy", busy_o, e_bsy);
        chk("R9 done", done_o, e_dn);
        chk("R6 err", err_o, e_er);
        chk("R2 nce", nf_nce_o, ce_off);
        start = go;
        nf_rb = rb_drv;
        tick();
    endtask

    task automatic idle_c(input logic bsy, input logic go, input string tg);
        cyc(0, 0, 1, 1, 0, 8'h00, 0, 8'h00, 0, bsy, 0, 0, go, tg);
    endtask

    task automatic bus_wr(input logic is_cmd, input logic [7:0] b);
        idle_c(1, 0, "R3");
        for (int i = 0; i < int'(tacls); i++) cyc(is_cmd, !is_cmd, 1, 1, 1, b, 0, 0, 0, 1, 0, 0, 0, "R3");
        for (int i = 0; i <= int'(tw0); i++)  cyc(is_cmd, !is_cmd, 0, 1, 1, b, 0, 0, 0, 1, 0, 0, 0, "R3");
        for (int i = 0; i <= int'(tw1); i++)  cyc(is_cmd, !is_cmd, 1, 1, 1, b, 0, 0, 0, 1, 0, 0, 0, "R3");
    endtask

    task automatic bus_rd(input int n, input logic sp, input string tg);
        idle_c(1, 0, tg);
        for (int i = 0; i < int'(tacls); i++) cyc(0, 0, 1, 1, 0, 0, 0, 0, 0, 1, 0, 0, 0, tg);
        for (int i = 0; i <= int'(tw0); i++)  cyc(0, 0, 1, 0, 0, 0, 0, 0, 0, 1, 0, 0, 0, tg);
        for (int i = 0; i <= int'(tw1); i++)  cyc(0, 0, 1, 1, 0, 0, (i == 0), pat(n), sp, 1, 0, 0, 0, tg);
    endtask

    task automatic launch(input logic id, input logic [27:0] a, input logic [3:0] ta, t0, t1,
                          input logic [15:0] lim, input logic [7:0] sd);
        op_id = id; addr = a; tacls = ta; tw0 = t0; tw1 = t1; limit = lim;
        seed = sd; rd_base = rd_cnt;
        idle_c(0, 1, "R9");
    endtask

    task automatic finish_op(input logic er);
        cyc(0, 0, 1, 1, 0, 0, 0, 0, 0, 1, 1, er, 0, "R9");
        idle_c(0, 0, "R9");
    endtask

    task automatic run_id(input logic [3:0] ta, t0, t1, input logic [7:0] sd);
        launch(1, 28'h0ABCDEF, ta, t0, t1, 16'd0, sd);
        bus_wr(1, 8'h90);
        bus_wr(0, 8'h00);
        for (int n = 0; n < 5; n++) bus_rd(n, 0, "R8");
        finish_op(0);
    endtask

    // busy_len: cycles after 0x30 (counted from the first blanked cycle) until the device is ready.
    task automatic run_page(input logic [27:0] a, input logic [3:0] ta, t0, t1,
                            input logic [15:0] lim, input int busy_len, input logic [7:0] sd);
        int w, t;
        logic s, ok;
        launch(0, a, ta, t0, t1, lim, sd);
        bus_wr(1, 8'h00);
        bus_wr(0, a[7:0]);
        bus_wr(0, {5'b0, a[10:8]});
        bus_wr(0, a[18:11]);
        bus_wr(0, a[26:19]);
        bus_wr(0, {7'b0, a[27]});
        bus_wr(1, 8'h30);
        rb_drv = 1'b0;
        w = 0;
        for (int i = 0; i < 4; i++) begin
            if (w == busy_len) rb_drv = 1'b1;
            idle_c(1, 0, "R5");
            w++;
        end
        t = 0; ok = 1'b0;
        forever begin
            if (w == busy_len) rb_drv = 1'b1;
            s = ms2;
            idle_c(1, 0, "R5");
            w++;
            if (s) begin ok = 1'b1; break; end
            if (t == int'(lim)) break;
            t++;
        end
        rb_drv = 1'b1;
        if (ok) begin
            for (int n = 0; n < 2112; n++) bus_rd(n, (n >= 2048), "R7");
            finish_op(0);
        end else begin
            finish_op(1);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (3) tick();
        @(negedge clk);
        chk("R1 cle in reset", nf_cle_o, 0);
        chk("R1 nwe in reset", nf_nwe_o, 1);
        chk("R1 nre in reset", nf_nre_o, 1);
        chk("R1 busy in reset", busy_o, 0);
        rst = 1'b0;
        tick();
        @(negedge clk);
        chk("R1 ale", nf_ale_o, 0);
        chk("R1 oe", nf_dq_oe_o, 0);
        chk("R1 done", done_o, 0);
        chk("R1 rd_valid", rd_valid_o, 0);
        tick();
        // R2: start refused while controller disabled, then while chip enable is off
        en = 1'b0; ce_off = 1'b0;
        idle_c(0, 1, "R2");
        for (int i = 0; i < 3; i++) idle_c(0, 0, "R2");
        en = 1'b1; ce_off = 1'b1;
        idle_c(0, 1, "R2");
        for (int i = 0; i < 3; i++) idle_c(0, 0, "R2");
        ce_off = 1'b0;
        idle_c(0, 0, "R2");
        run_id(4'd1, 4'd1, 4'd1, 8'h11);
        run_page(28'h8A5C3F1, 4'd0, 4'd0, 4'd0, 16'd100, 10, 8'h23);
        run_page(28'h7F00E07, 4'd2, 4'd3, 4'd1, 16'd50, 2, 8'h5A);
        run_page(28'h0123456, 4'd1, 4'd0, 4'd2, 16'd5, 1000, 8'h00);
        run_id(4'd0, 4'd2, 4'd0, 8'hC3);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule